// File: doc/BRIEF.md
# Data Address Stride Compressor

This block shrinks the data-address trace produced by a processor's loads and stores. Each memory-referencing instruction presents a word index taken from its program counter together with the 32-bit address it touched. A table with one entry per index remembers the previous address seen for that index and a short signed stride. When the new address equals the remembered address plus the sign-extended stride, the reference costs a single '1' bit. Otherwise the block writes a '0' bit, sends the full address out on a separate miss stream, and learns the low byte of the new difference as its stride.

References pass through a small queue and then a two-stage lookup. The hit and miss bits are gathered into bytes, first reference in the least significant bit. A flush request pushes out a partly filled byte together with its bit count. The table has no tags, so two instructions that share an index also share an entry.

Top module: `dsc_top`

## Requirements
- R1: In reset and on its first cycle after reset, `in_ready` is 1 and `miss_valid` and `trace_valid` are 0. Every entry starts with a last address of 0 and a stride of 0, so a first reference to address 0 is a hit and a first reference to any other address is a miss.
- R2: Each value of `in_pc_idx` selects its own entry. References on one index never change the prediction made for another index.
- R3: A reference is a hit when (address − last address) mod 2^32 equals the stored 8-bit stride sign-extended to 32 bits. This covers negative strides: for example, after addresses 0x2000 and 0x1FF8, the address 0x1FF0 is a hit.
- R4: On a miss, `miss_valid` pulses for one cycle carrying the full address, and bits [7:0] of the difference become the entry's new stride. On a hit, nothing appears on the miss stream.
- R5: The entry's last address is replaced by the incoming address on every reference, whether it hit or missed.
- R6: A constant stride that does not fit in a signed byte (for example 0x100) misses on every reference.
- R7: For an input sampled at clock edge k, the miss-stream result appears after edge k+2, and so does any trace byte that this reference completes.
- R8: Result bits fill a byte from bit 0 upward in reference order. After the eighth bit, `trace_valid` pulses with `trace_nbits` = 8.
- R9: A `flush` sampled at edge f with n pending bits (n from 1 to 7) emits a byte after edge f with `trace_nbits` = n, the bits above n−1 set to zero, and the count restarted at 0. A flush with no pending bits emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A reference is presented this cycle |
| in_pc_idx | input | 10 | Word-index bits [11:2] of the referencing instruction's PC |
| in_addr | input | 32 | Data address of the reference |
| in_ready | output | 1 | Input queue can accept a reference |
| flush | input | 1 | Emit the partly filled trace byte |
| miss_valid | output | 1 | A mispredicted address is on `miss_addr` |
| miss_addr | output | 32 | Full mispredicted data address |
| trace_valid | output | 1 | A hit/miss byte is on `trace_byte` |
| trace_byte | output | 8 | Packed hit (1) / miss (0) bits, oldest in bit 0 |
| trace_nbits | output | 4 | Number of valid bits in `trace_byte` (1 to 8) |

## Verification
An input driven just before edge k is written into the queue at k, popped into the lookup stage at k+1, and resolved at k+2. The bench therefore gives each expected miss address and each completed byte a due cycle of k+2 and compares it at the falling edge after that clock. A flush has a single register on its path, so its partial byte is due one cycle after the flush is sampled. Any output that arrives early or late, or that has no expected event waiting, fails the check.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int ADDR_W   = 32;
    localparam int STRIDE_W = 8;
    localparam int BYTE_W   = 8;

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [STRIDE_W-1:0] stride_t;

    // Outcome of one table lookup
    typedef struct packed {
        logic  valid;
        logic  hit;
        addr_t addr;
    } lookup_res_t;

    function automatic addr_t widen_stride(stride_t s);
        return {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
    endfunction
endpackage

// File: rtl/dsc_fifo.sv
module dsc_fifo #(
    parameter int WIDTH = 42,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;

    assign full  = (count == (PTR_W+1)'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end
endmodule

// File: rtl/dsc_table.sv
module dsc_table
    import dsc_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  addr_t            req_addr,
    output lookup_res_t      res
);
    localparam int ENTRIES = 1 << IDX_W;

    addr_t   last_q   [ENTRIES];
    stride_t stride_q [ENTRIES];

    logic             s1_v;
    logic [IDX_W-1:0] s1_idx;
    addr_t            s1_addr;

    addr_t delta;
    logic  match;

    always_comb begin
        delta = s1_addr - last_q[s1_idx];
        match = (delta == widen_stride(stride_q[s1_idx]));
    end

    assign res = '{valid: s1_v, hit: match, addr: s1_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                last_q[i]   <= '0;
                stride_q[i] <= '0;
            end
            s1_v <= 1'b0;
        end else begin
            s1_v <= req_valid;
            if (req_valid) begin
                s1_idx  <= req_idx;
                s1_addr <= req_addr;
            end
            if (s1_v) begin
                last_q[s1_idx] <= s1_addr;
                if (!match) stride_q[s1_idx] <= delta[STRIDE_W-1:0];
            end
        end
    end

    // R5
    last_addr_upd_chk: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> last_q[$past(s1_idx)] == $past(s1_addr));

    // R4
    stride_learn_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_v && !match) |=> stride_q[$past(s1_idx)] == $past(delta[STRIDE_W-1:0]));
endmodule

// File: rtl/dsc_packer.sv
module dsc_packer
    import dsc_pkg::*;
#(
    localparam int CNT_W = $clog2(BYTE_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              flush,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic [CNT_W-1:0]  out_nbits
);
    logic [BYTE_W-1:0] acc_q, merged;
    logic [CNT_W-1:0]  cnt_q, cnt_next;
    logic              emit;

    always_comb begin
        merged = acc_q;
        if (bit_valid) merged[cnt_q[CNT_W-2:0]] = bit_val;
        cnt_next = cnt_q + CNT_W'(bit_valid);
        emit = (cnt_next == CNT_W'(BYTE_W)) || (flush && cnt_next != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_nbits <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_byte  <= merged;
                out_nbits <= cnt_next;
                acc_q     <= '0;
                cnt_q     <= '0;
            end else begin
                acc_q <= merged;
                cnt_q <= cnt_next;
            end
        end
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(BYTE_W));

    // R9
    partial_needs_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nbits != CNT_W'(BYTE_W)) |-> $past(flush));
endmodule

// File: rtl/dsc_top.sv
module dsc_top
    import dsc_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(BYTE_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_pc_idx,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              in_ready,
    input  logic              flush,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_addr,
    output logic              trace_valid,
    output logic [BYTE_W-1:0] trace_byte,
    output logic [CNT_W-1:0]  trace_nbits
);
    localparam int ENTRY_W = IDX_W + ADDR_W;

    logic               q_full, q_empty, q_pop;
    logic [ENTRY_W-1:0] q_out;
    lookup_res_t        res;

    assign in_ready = !q_full;
    assign q_pop    = !q_empty;

    dsc_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid && !q_full),
        .din   ({in_pc_idx, in_addr}),
        .full  (q_full),
        .pop   (q_pop),
        .dout  (q_out),
        .empty (q_empty)
    );

    dsc_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .req_valid (q_pop),
        .req_idx   (q_out[ENTRY_W-1:ADDR_W]),
        .req_addr  (q_out[ADDR_W-1:0]),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_valid <= 1'b0;
            miss_addr  <= '0;
        end else begin
            miss_valid <= res.valid && !res.hit;
            if (res.valid && !res.hit) miss_addr <= res.addr;
        end
    end

    dsc_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (res.valid),
        .bit_val   (res.hit),
        .flush     (flush),
        .out_valid (trace_valid),
        .out_byte  (trace_byte),
        .out_nbits (trace_nbits)
    );

    // R7
    miss_latency_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> $past(q_pop, 2));
endmodule

// File: tb/tb_dsc_top.sv
module tb_dsc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [9:0]  in_pc_idx;
    logic [31:0] in_addr;
    logic        in_ready;
    logic        flush;
    logic        miss_valid;
    logic [31:0] miss_addr;
    logic        trace_valid;
    logic [7:0]  trace_byte;
    logic [3:0]  trace_nbits;

    always #10 clk = ~clk;

    dsc_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc_idx(in_pc_idx),
        .in_addr(in_addr), .in_ready(in_ready), .flush(flush),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .trace_valid(trace_valid), .trace_byte(trace_byte), .trace_nbits(trace_nbits)
    );

    typedef struct { int due; logic [31:0] a; } miss_ev_t;
    typedef struct { int due; logic [7:0] b; int n; } byte_ev_t;

    miss_ev_t    mq[$];
    byte_ev_t    bq[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] m_last [1024];
    logic [7:0]  m_str  [1024];
    logic [7:0]  bacc;
    int          bcnt;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endfunction

    function automatic void summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endfunction

    // Reference model built from R1-style rules stated per requirement: R3 R4 R5
    function automatic void model(int idx, logic [31:0] a, int due);
        logic [31:0] d = a - m_last[idx];
        bit hit = (d == {{24{m_str[idx][7]}}, m_str[idx]});
        if (!hit) begin
            m_str[idx] = d[7:0];
            mq.push_back('{due, a});
        end
        m_last[idx] = a;
        bacc[bcnt] = hit;
        bcnt++;
        if (bcnt == 8) begin
            bq.push_back('{due, bacc, 8});
            bacc = '0;
            bcnt = 0;
        end
    endfunction

    task automatic send(int idx, logic [31:0] a);
        @(negedge clk);
        in_valid  = 1'b1;
        in_pc_idx = 10'(idx);
        in_addr   = a;
        flush     = 1'b0;
        model(idx, a, cyc + 3);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            flush    = 1'b0;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b1;
        if (bcnt > 0) bq.push_back('{cyc + 1, bacc, bcnt});
        bacc = '0;
        bcnt = 0;
    endtask

    // Output monitor: R7 timing, R4 miss stream, R8/R9 bytes
    always @(negedge clk) begin
        if (!rst) begin
            if (miss_valid) begin
                if (mq.size() == 0) chk(0, "R4 unexpected miss", miss_addr, 0);
                else begin
                    chk(mq[0].due == cyc && mq[0].a == miss_addr, "R4/R7 miss addr",
                        miss_addr, mq[0].a);
                    void'(mq.pop_front());
                end
            end else if (mq.size() > 0 && mq[0].due <= cyc) begin
                chk(0, "R7 missing miss", 0, mq[0].a);
                void'(mq.pop_front());
            end
            if (trace_valid) begin
                if (bq.size() == 0) chk(0, "R9 unexpected byte", {24'h0, trace_byte}, 0);
                else begin
                    chk(bq[0].due == cyc && bq[0].b == trace_byte && bq[0].n == int'(trace_nbits),
                        "R8/R9 trace byte", {20'h0, trace_nbits, trace_byte},
                        {20'h0, 4'(bq[0].n), bq[0].b});
                    void'(bq.pop_front());
                end
            end else if (bq.size() > 0 && bq[0].due <= cyc) begin
                chk(0, "R8 missing byte", 0, {24'h0, bq[0].b});
                void'(bq.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(0, "watchdog", 0, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] s_last [6];
        int          s_idx  [6];
        logic [31:0] s_step [6];
        for (int i = 0; i < 1024; i++) begin m_last[i] = '0; m_str[i] = '0; end
        bacc = '0; bcnt = 0;
        rst = 1'b1; in_valid = 1'b0; in_pc_idx = '0; in_addr = '0; flush = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 1);
        chk(miss_valid == 1'b0, "R1 miss_valid in reset", 32'(miss_valid), 0);
        chk(trace_valid == 1'b0, "R1 trace_valid in reset", 32'(trace_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(miss_valid == 1'b0 && trace_valid == 1'b0, "R1 idle after reset",
            {30'h0, miss_valid, trace_valid}, 0);

        // R1: cleared entries; R3 positive stride; R5
        send(5, 32'h0);
        send(5, 32'h1000);
        send(5, 32'h1004);
        send(5, 32'h1008);
        send(5, 32'h100C);
        // R3 negative stride
        send(7, 32'h2000);
        send(7, 32'h1FF8);
        send(7, 32'h1FF0);
        // R6 stride too wide
        send(9, 32'h100);
        send(9, 32'h200);
        send(9, 32'h300);
        // R2: interleaved streams on separate entries keep their strides
        send(20, 32'h5000); send(21, 32'h9000);
        send(20, 32'h5010); send(21, 32'h8FFC);
        send(20, 32'h5020); send(21, 32'h8FF8);
        send(20, 32'h5030); send(21, 32'h8FF4);
        idle(5);
        // R9: partial byte, then an empty flush
        do_flush();
        do_flush();
        idle(1);
        chk(trace_valid == 1'b0, "R9 empty flush emits nothing", 32'(trace_valid), 0);
        idle(3);
        chk(bq.size() == 0 && mq.size() == 0, "R9 directed events drained",
            32'(bq.size() + mq.size()), 0);

        // Constrained random streams
        void'($urandom(32'd2024));
        for (int s = 0; s < 6; s++) begin
            s_idx[s]  = 100 + s * 37;
            s_last[s] = $urandom();
            s_step[s] = ($urandom_range(0, 3) == 0) ? 32'h140 : 32'($urandom_range(0, 40)) - 32'd20;
        end
        s_idx[5] = s_idx[4]; // two streams aliasing one entry
        for (int n = 0; n < 3000; n++) begin
            int s = $urandom_range(0, 5);
            if ($urandom_range(0, 9) == 0) s_last[s] = $urandom();
            else s_last[s] = s_last[s] + s_step[s];
            send(s_idx[s], s_last[s]);
            if ($urandom_range(0, 7) == 0) idle(1);
            if ($urandom_range(0, 199) == 0) begin
                idle(4);
                do_flush();
            end
        end
        idle(5);
        do_flush();
        idle(5);
        chk(bq.size() == 0 && mq.size() == 0, "R7 all events delivered",
            32'(bq.size() + mq.size()), 0);
        summary();
        $finish;
    end
endmodule